// File: doc/BRIEF.md
# Serial Output Stop Register

This block is the receiver for a one-wire control stream that turns individual clock outputs of a clock generator on and off. It runs on a free-running serial clock. The data line rests high. A frame is a single low start bit, then twelve data bits, one bit per serial clock period. Each data bit is sampled on a rising edge of the serial clock.

While a frame is arriving, its bits collect in a shadow register. The exported enable vector does not change during the frame. On the edge that samples the twelfth data bit, the whole vector is replaced in one step. The output gating logic uses this vector to hold stopped outputs low.

Two outputs, the first output of bank C and the feedback output, never appear in a frame and stay running at all times. A synchronous active-high master reset clears the receiver and enables every output.

Top module: `serial_stop_reg`

## Requirements
- R1: While reset is high, and on the first clock after reset is released, `out_en` is all ones and the receiver is waiting for a start bit.
- R2: While the receiver is waiting for a start bit, a high level on `ser_din` has no effect, and `out_en` keeps its value.
- R3: A low level sampled on `ser_din` while the receiver is waiting is a start bit. The next twelve rising edges each sample one data bit.
- R4: The data bits fill `out_en` in arrival order. The first data bit goes to bit 0 and the twelfth goes to bit 11. Bits 0..3 control bank A outputs 0..3, bits 4..7 control bank B outputs 0..3, bits 8..10 control bank C outputs 1..3, and bit 11 controls the sync output.
- R5: A data bit of 0 sets its enable to 0 (output stopped). A data bit of 1 sets its enable to 1 (output running).
- R6: `out_en` changes only on the edge that samples the twelfth data bit, and then all of its bits change together. During the start bit and data bits 1 to 11 it holds its previous value.
- R7: After the twelfth data bit the receiver waits for a start bit again. A start bit on the very next edge begins a new frame with no idle gap.
- R8: A zero data bit inside a frame is never taken as a start bit. Exactly twelve bits are counted, even when all of them are zero.
- R9: Reset in the middle of a frame throws away the partial frame and restores every enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high master reset |
| ser_din | input | 1 | Serial data line, high when idle |
| out_en | output | 12 | Registered per-output enables, 1 = running |

## Verification
The assertions check, on every cycle, how the receiver moves between waiting and receiving. A high level while waiting keeps it waiting. A start bit always leads to data bit 0. The twelfth bit always returns it to waiting. Every sampled data bit lands at the top of the shadow register, and `out_en` stays stable except on the commit edge. Only the bench scenarios can show the rest against the reference model: that each bit ends up at the correct enable position, that back-to-back frames are both taken, that an all-zero frame leaves no false start bit behind, and that a reset in the middle of a frame discards the partial data.

// File: rtl/stopreg_pkg.sv
package stopreg_pkg;

  // Receiver phase: hunting for a start bit, or collecting data bits
  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;

endpackage

// File: rtl/stopreg_framer.sv
module stopreg_framer
  import stopreg_pkg::*;
#(
  parameter int NUM_EN = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic shift_en,
  output logic last_bit
);

  localparam int CNT_W = (NUM_EN > 1) ? $clog2(NUM_EN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_EN - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign shift_en = (state_q == RX_DATA);
  assign last_bit = (state_q == RX_DATA) && (cnt_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      RX_HUNT: begin
        if (!din) begin
          state_d = RX_DATA;
          cnt_d   = '0;
        end
      end
      RX_DATA: begin
        if (cnt_q == LAST_IDX) begin
          state_d = RX_HUNT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = RX_HUNT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2
  idle_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_HUNT && din) |=> (state_q == RX_HUNT));

  // R3
  start_enters_data_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_HUNT && !din) |=> (state_q == RX_DATA && cnt_q == '0));

  // R7
  frame_end_hunt_chk: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> (state_q == RX_HUNT));

  // R8
  data_zero_not_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_DATA && !last_bit) |=> (state_q == RX_DATA && cnt_q != '0));

endmodule

// File: rtl/stopreg_shifter.sv
module stopreg_shifter #(
  parameter int NUM_EN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [NUM_EN-1:0] shadow_next
);

  logic [NUM_EN-1:0] shadow_q;

  // New bits enter at the top; after NUM_EN shifts the first bit sits at bit 0
  generate
    if (NUM_EN > 1) begin : g_multi
      assign shadow_next = {din, shadow_q[NUM_EN-1:1]};
    end else begin : g_single
      assign shadow_next = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '1;
    end else if (shift_en) begin
      shadow_q <= shadow_next;
    end
  end

  // R4
  shadow_entry_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (shadow_q[NUM_EN-1] == $past(din)));

endmodule

// File: rtl/stopreg_hold.sv
module stopreg_hold #(
  parameter int NUM_EN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NUM_EN-1:0] load_val,
  output logic [NUM_EN-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '1;
    end else if (load) begin
      en_q <= load_val;
    end
  end

  // R6
  en_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(en_q));

endmodule

// File: rtl/serial_stop_reg.sv
module serial_stop_reg #(
  parameter int NUM_EN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_din,
  output logic [NUM_EN-1:0] out_en
);

  logic              shift_en;
  logic              last_bit;
  logic [NUM_EN-1:0] shadow_next;

  stopreg_framer #(.NUM_EN(NUM_EN)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .din      (ser_din),
    .shift_en (shift_en),
    .last_bit (last_bit)
  );

  stopreg_shifter #(.NUM_EN(NUM_EN)) u_shifter (
    .clk         (clk),
    .rst         (rst),
    .shift_en    (shift_en),
    .din         (ser_din),
    .shadow_next (shadow_next)
  );

  // Commit on the edge that samples the last data bit, so back-to-back frames fit
  stopreg_hold #(.NUM_EN(NUM_EN)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (last_bit),
    .load_val (shadow_next),
    .en_q     (out_en)
  );

endmodule

// File: tb/serial_stop_reg_bench.sv
module serial_stop_reg_bench;

  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         din = 1'b1;
  logic [N-1:0] out_en;

  int checks = 0;
  int errors = 0;

  // reference model state
  int           m_phase = 0;   // 0 hunting, 1 receiving
  int           m_cnt   = 0;
  logic [N-1:0] m_bits  = '1;
  logic [N-1:0] m_en    = '1;

  always #4 clk = ~clk;   // 125 MHz

  serial_stop_reg #(.NUM_EN(N)) u_serial_stop_reg (
    .clk     (clk),
    .rst     (rst),
    .ser_din (din),
    .out_en  (out_en)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic r, input logic d);
    if (r) begin
      m_phase = 0; m_cnt = 0; m_en = '1;
    end else if (m_phase == 0) begin
      if (d == 1'b0) begin
        m_phase = 1; m_cnt = 0;
      end
    end else begin
      m_bits[m_cnt] = d;
      if (m_cnt == N - 1) begin
        m_en = m_bits; m_phase = 0; m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  endtask

  // one serial clock: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input logic d);
    din = d;
    @(posedge clk);
    model_step(rst, d);
    @(negedge clk);
    check("R4 R5 R6 cycle model", out_en, m_en);
  endtask

  task automatic send_frame(input logic [N-1:0] v);
    tick(1'b0);
    for (int i = 0; i < N; i++) tick(v[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(1'b1);
    tick(1'b0);                         // zero during reset is ignored
    check("R1 during reset", out_en, '1);
    rst = 1'b0;
    tick(1'b1);
    check("R1 after reset", out_en, '1);

    for (int i = 0; i < 20; i++) tick(1'b1);
    check("R2 idle high no effect", out_en, '1);

    send_frame(12'hA5C);
    check("R3 R5 frame A5C", out_en, 12'hA5C);

    send_frame(12'hFFE);
    check("R4 first bit to en[0]", out_en, 12'hFFE);
    tick(1'b1);
    send_frame(12'h7FF);
    check("R4 last bit to en[11]", out_en, 12'h7FF);

    tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 6; i++) tick(1'b0);
    check("R6 mid frame holds", out_en, 12'h7FF);
    for (int i = 6; i < N - 1; i++) tick(1'b0);
    check("R6 before last bit holds", out_en, 12'h7FF);
    tick(1'b1);
    check("R6 commit at twelfth bit", out_en, 12'h800);

    send_frame(12'h3C3);
    send_frame(12'h0F0);
    check("R7 back to back second frame", out_en, 12'h0F0);

    send_frame(12'h000);
    check("R8 all zero frame", out_en, 12'h000);
    for (int i = 0; i < 30; i++) tick(1'b1);
    check("R8 no false start after zeros", out_en, 12'h000);

    send_frame(12'h555);
    tick(1'b0);
    for (int i = 0; i < 5; i++) tick(1'b0);
    rst = 1'b1;
    tick(1'b1);
    rst = 1'b0;
    check("R9 reset mid frame", out_en, '1);
    for (int i = 0; i < 10; i++) tick(1'b1);
    check("R9 partial frame dropped", out_en, '1);
    send_frame(12'h9A6);
    check("R9 clean frame after reset", out_en, 12'h9A6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule